// File: doc/BRIEF.md
# Bus Error and Machine-Check Generator

This block sits inside a memory controller and decides, once per bus access, whether the access ends with a transfer-error acknowledge and whether it raises a machine-check interrupt. An access opens with a start strobe that carries its attributes: target region, alignment and beat type. It closes either with an end strobe or with a time-out pulse from the bus monitor. While the access is open, the data path may report parity errors, uncorrectable (double-bit) ECC errors and corrected (single-bit) ECC errors. These reports are held until the access closes.

When the access closes, the block evaluates everything that was gathered. It emits at most one transfer-error pulse and at most one machine-check pulse. Both pulses are registered and appear in the cycle after the closing edge. Corrected single-bit errors are counted rather than reported. A machine check from that source comes only once the count reaches a programmable limit. Software can clear the count with a strobe, and the count is visible on an output.

Top module: `bus_err_mchk`

## Requirements
- R1: While reset is held and after it is released, `tea_o` and `mchk_o` are 0 and `sbe_count_o` is 0.
- R2: With `tea_en_i` high, an access whose start carries region code 2'b01 (internal registers) with `acc_unaligned_i` high gives `tea_o` high for one cycle, in the cycle after the closing edge.
- R3: With `tea_en_i` high, a burst access (`acc_burst_i` high at start) to region 2'b01 or to region 2'b10 (local bus) gives a `tea_o` pulse in the cycle after the closing edge.
- R4: A `bm_timeout_i` pulse while an access is open closes that access and, with `tea_en_i` high, gives a `tea_o` pulse in the next cycle. A time-out when no access is open has no effect. An end strobe with no open access has no effect.
- R5: Nothing else produces `tea_o`, and `tea_o` stays 0 while `tea_en_i` is low. This covers unaligned or single-beat accesses to region 2'b10 and any access to regions 2'b00 and 2'b11.
- R6: With `mchk_en_i` high, a parity error or an ECC double-bit error seen during an access gives an `mchk_o` pulse in the cycle after the closing edge.
- R7: Each closed access that saw at least one single-bit indication adds exactly one to `sbe_count_o`. The count saturates at `sbe_max_i`.
- R8: A single-bit indication raises `mchk_o` only when the count after that access's step equals or exceeds `sbe_max_i`. With a limit of 0, every such access raises it.
- R9: `sbe_clr_i` sets `sbe_count_o` to 0 on the next edge. A clear wins over an increment in the same cycle.
- R10: However many conditions one access accumulates, it produces at most one `tea_o` cycle and at most one `mchk_o` cycle, both in the same cycle.
- R11: With `mchk_en_i` low, no `mchk_o` pulse is produced, but the single-bit count still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_start_i | input | 1 | First cycle of an access; attributes valid |
| acc_end_i | input | 1 | Last cycle of an access |
| acc_region_i | input | 2 | Target region: 00 other, 01 internal registers, 10 local bus, 11 other |
| acc_unaligned_i | input | 1 | Access is not naturally aligned |
| acc_burst_i | input | 1 | Access is a burst |
| bm_timeout_i | input | 1 | Bus-monitor time-out pulse |
| parity_err_i | input | 1 | Parity error on a data beat |
| ecc_dbl_i | input | 1 | Uncorrectable ECC error on a data beat |
| ecc_sgl_i | input | 1 | Corrected ECC error on a data beat |
| tea_en_i | input | 1 | Enables transfer-error generation |
| mchk_en_i | input | 1 | Enables machine-check generation |
| sbe_max_i | input | CNT_W | Single-bit error count limit |
| sbe_clr_i | input | 1 | Clears the single-bit error count |
| tea_o | output | 1 | Transfer-error acknowledge pulse |
| mchk_o | output | 1 | Machine-check interrupt pulse |
| sbe_count_o | output | CNT_W | Current single-bit error count |

## Verification
The transfer-error and machine-check decisions can fall due in the same cycle. This happens when one access both breaks an access rule (or times out) and sees a data error. The bench provokes this with single-cycle vectors that pair an illegal burst with a double-bit error. It also runs a multi-cycle access that gathers a burst violation, a parity error, a double-bit error and a time-out in different beats. The bench judges the result by counting how many cycles each output is high over the following window, expecting exactly one cycle each, with both pulses in the same cycle. The counter limit is exercised at its edge and past it, and with a limit of zero.

// File: rtl/berr_pkg.sv
package berr_pkg;

  typedef enum logic [1:0] {
    RGN_OTHER0 = 2'b00,
    RGN_INTREG = 2'b01,
    RGN_LOCAL  = 2'b10,
    RGN_OTHER3 = 2'b11
  } region_e;

  typedef struct packed {
    logic rule;   // access-type rule broken at start
    logic tmo;    // bus monitor time-out
    logic par;    // parity error
    logic dbl;    // uncorrectable ECC error
    logic sgl;    // corrected ECC error
  } err_flags_t;

  function automatic logic rule_broken(input logic [1:0] rgn,
                                       input logic unal,
                                       input logic burst);
    logic bad;
    bad = 1'b0;
    if (rgn == RGN_INTREG) bad = unal | burst;
    else if (rgn == RGN_LOCAL) bad = burst;
    return bad;
  endfunction

endpackage

// File: rtl/berr_rst_sync.sv
module berr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/berr_collect.sv
module berr_collect
  import berr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_start_i,
  input  logic       acc_end_i,
  input  logic [1:0] acc_region_i,
  input  logic       acc_unaligned_i,
  input  logic       acc_burst_i,
  input  logic       bm_timeout_i,
  input  logic       parity_err_i,
  input  logic       ecc_dbl_i,
  input  logic       ecc_sgl_i,
  output logic       open_o,
  output logic       close_o,
  output err_flags_t flags_o
);

  logic       active_q, active_d;
  err_flags_t flags_q, flags_d, now_s;
  logic       keep_s;

  always_comb begin
    open_o    = active_q | acc_start_i;
    close_o   = open_o & (acc_end_i | bm_timeout_i);
    keep_s    = open_o & ~close_o;
    now_s.rule = acc_start_i & rule_broken(acc_region_i, acc_unaligned_i, acc_burst_i);
    now_s.tmo  = open_o & bm_timeout_i;
    now_s.par  = open_o & parity_err_i;
    now_s.dbl  = open_o & ecc_dbl_i;
    now_s.sgl  = open_o & ecc_sgl_i;
    flags_o   = err_flags_t'(flags_q | now_s);
    active_d  = keep_s;
    flags_d   = keep_s ? flags_o : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      flags_q  <= '0;
    end else begin
      active_q <= active_d;
      flags_q  <= flags_d;
    end
  end

endmodule

// File: rtl/berr_sbe_counter.sv
module berr_sbe_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] max_i,
  output logic             limit_hit_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, sat_s;
  logic             cnt_en;

  always_comb begin
    sat_s       = (cnt_q >= max_i) ? cnt_q : cnt_q + ONE;
    limit_hit_o = step_i & (sat_s >= max_i);
    cnt_en      = step_i | clr_i;
    cnt_d       = clr_i ? '0 : sat_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/berr_pulse_gen.sv
module berr_pulse_gen
  import berr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       close_i,
  input  err_flags_t flags_i,
  input  logic       sbe_limit_i,
  input  logic       tea_en_i,
  input  logic       mchk_en_i,
  output logic       tea_o,
  output logic       mchk_o
);

  logic tea_q, tea_d, mchk_q, mchk_d;

  always_comb begin
    tea_d  = close_i & tea_en_i  & (flags_i.rule | flags_i.tmo);
    mchk_d = close_i & mchk_en_i & (flags_i.par | flags_i.dbl | sbe_limit_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tea_q  <= 1'b0;
      mchk_q <= 1'b0;
    end else begin
      tea_q  <= tea_d;
      mchk_q <= mchk_d;
    end
  end

  assign tea_o  = tea_q;
  assign mchk_o = mchk_q;

endmodule

// File: rtl/bus_err_mchk.sv
module bus_err_mchk
  import berr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RST_STAGE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_start_i,
  input  logic             acc_end_i,
  input  logic [1:0]       acc_region_i,
  input  logic             acc_unaligned_i,
  input  logic             acc_burst_i,
  input  logic             bm_timeout_i,
  input  logic             parity_err_i,
  input  logic             ecc_dbl_i,
  input  logic             ecc_sgl_i,
  input  logic             tea_en_i,
  input  logic             mchk_en_i,
  input  logic [CNT_W-1:0] sbe_max_i,
  input  logic             sbe_clr_i,
  output logic             tea_o,
  output logic             mchk_o,
  output logic [CNT_W-1:0] sbe_count_o
);

  logic       rst_sync_n;
  logic       acc_open;
  logic       acc_close;
  logic       sbe_limit;
  err_flags_t flags;

  berr_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  berr_collect u_collect (
    .clk_i           (clk_i),
    .rst_ni          (rst_sync_n),
    .acc_start_i     (acc_start_i),
    .acc_end_i       (acc_end_i),
    .acc_region_i    (acc_region_i),
    .acc_unaligned_i (acc_unaligned_i),
    .acc_burst_i     (acc_burst_i),
    .bm_timeout_i    (bm_timeout_i),
    .parity_err_i    (parity_err_i),
    .ecc_dbl_i       (ecc_dbl_i),
    .ecc_sgl_i       (ecc_sgl_i),
    .open_o          (acc_open),
    .close_o         (acc_close),
    .flags_o         (flags)
  );

  berr_sbe_counter #(.CNT_W(CNT_W)) u_sbe (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .step_i      (acc_close & flags.sgl),
    .clr_i       (sbe_clr_i),
    .max_i       (sbe_max_i),
    .limit_hit_o (sbe_limit),
    .count_o     (sbe_count_o)
  );

  berr_pulse_gen u_pulse (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .close_i     (acc_close),
    .flags_i     (flags),
    .sbe_limit_i (sbe_limit),
    .tea_en_i    (tea_en_i),
    .mchk_en_i   (mchk_en_i),
    .tea_o       (tea_o),
    .mchk_o      (mchk_o)
  );

endmodule

// File: rtl/berr_chk.sv
module berr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             acc_open,
  input logic             acc_start_i,
  input logic             acc_end_i,
  input logic [1:0]       acc_region_i,
  input logic             acc_unaligned_i,
  input logic             bm_timeout_i,
  input logic             parity_err_i,
  input logic             ecc_dbl_i,
  input logic             tea_en_i,
  input logic             mchk_en_i,
  input logic             sbe_clr_i,
  input logic             tea_o,
  input logic             mchk_o,
  input logic [CNT_W-1:0] sbe_count_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_int_unaligned_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (acc_start_i && acc_end_i && acc_region_i == 2'b01 && acc_unaligned_i && tea_en_i) |=> tea_o);

  p_timeout_tea_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (acc_open && bm_timeout_i && tea_en_i) |=> tea_o);

  p_tea_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    tea_o |-> $past(tea_en_i));

  p_hard_err_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (acc_open && acc_end_i && (parity_err_i || ecc_dbl_i) && mchk_en_i) |=> mchk_o);

  p_count_step_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sbe_count_o != $past(sbe_count_o)) |->
      (sbe_count_o == $past(sbe_count_o) + ONE || sbe_count_o == '0));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    sbe_clr_i |=> (sbe_count_o == '0));

  p_tea_on_close_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    tea_o |-> $past(acc_open && (acc_end_i || bm_timeout_i)));

  p_mchk_on_close_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    mchk_o |-> $past(acc_open && (acc_end_i || bm_timeout_i)));

  p_mchk_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    mchk_o |-> $past(mchk_en_i));

endmodule

bind bus_err_mchk berr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_n           (rst_sync_n),
  .acc_open        (acc_open),
  .acc_start_i     (acc_start_i),
  .acc_end_i       (acc_end_i),
  .acc_region_i    (acc_region_i),
  .acc_unaligned_i (acc_unaligned_i),
  .bm_timeout_i    (bm_timeout_i),
  .parity_err_i    (parity_err_i),
  .ecc_dbl_i       (ecc_dbl_i),
  .tea_en_i        (tea_en_i),
  .mchk_en_i       (mchk_en_i),
  .sbe_clr_i       (sbe_clr_i),
  .tea_o           (tea_o),
  .mchk_o          (mchk_o),
  .sbe_count_o     (sbe_count_o)
);

// File: tb/test_bus_err_mchk.sv
module test_bus_err_mchk;

  localparam int CNT_W = 8;
  localparam int NVEC  = 12;

  // {region[9:8], unal, burst, par, dbl, tea_en, mchk_en, exp_tea, exp_mchk}
  localparam logic [9:0] VEC [0:NVEC-1] = '{
    10'b01_1_0_0_0_1_1_1_0,  // R2 internal unaligned
    10'b01_0_1_0_0_1_1_1_0,  // R3 internal burst
    10'b10_0_1_0_0_1_1_1_0,  // R3 local burst
    10'b10_1_0_0_0_1_1_0_0,  // R5 local unaligned single
    10'b00_0_1_0_0_1_1_0_0,  // R5 other-region burst
    10'b01_0_0_0_0_1_1_0_0,  // R5 internal aligned single
    10'b01_1_0_0_0_0_1_0_0,  // R5 tea disabled
    10'b00_0_0_1_0_1_1_0_1,  // R6 parity
    10'b11_0_0_0_1_1_1_0_1,  // R6 double-bit
    10'b00_0_0_1_0_1_0_0_0,  // R11 parity, mchk disabled
    10'b01_0_1_0_1_1_1_1_1,  // R10 rule + double-bit
    10'b11_1_1_1_1_1_1_0_1   // R10 many conditions, other region
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             st, en, un, bu, tmo, par, dbl, sgl, tea_en, mchk_en, clr;
  logic [1:0]       rgn;
  logic [CNT_W-1:0] smax;
  logic             tea, mchk;
  logic [CNT_W-1:0] cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bus_err_mchk #(.CNT_W(CNT_W)) i_bus_err_mchk (
    .clk_i (clk), .rst_ni (rst_n),
    .acc_start_i (st), .acc_end_i (en), .acc_region_i (rgn),
    .acc_unaligned_i (un), .acc_burst_i (bu), .bm_timeout_i (tmo),
    .parity_err_i (par), .ecc_dbl_i (dbl), .ecc_sgl_i (sgl),
    .tea_en_i (tea_en), .mchk_en_i (mchk_en), .sbe_max_i (smax), .sbe_clr_i (clr),
    .tea_o (tea), .mchk_o (mchk), .sbe_count_o (cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    st = 0; en = 0; un = 0; bu = 0; tmo = 0; par = 0; dbl = 0; sgl = 0; clr = 0;
    rgn = 2'b00;
  endtask

  // single-cycle access; on return outputs reflect it
  task automatic acc1(input logic [1:0] r, input logic u, b, p, d, s, c);
    @(negedge clk);
    st = 1; en = 1; rgn = r; un = u; bu = b; par = p; dbl = d; sgl = s; clr = c;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int nt, nm, both;
    idle();
    tea_en = 1; mchk_en = 1; smax = 8'd3;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 tea in reset", tea, 0);
    chk("R1 mchk in reset", mchk, 0);
    chk("R1 count in reset", cnt, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 tea after reset", tea, 0);
    chk("R1 count after reset", cnt, 0);

    for (int i = 0; i < NVEC; i++) begin
      tea_en  = VEC[i][3];
      mchk_en = VEC[i][2];
      acc1(VEC[i][9:8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], 1'b0, 1'b0);
      chk($sformatf("R2/R3/R5/R6/R10/R11 vec %0d tea", i), tea, VEC[i][1]);
      chk($sformatf("R6/R10/R11 vec %0d mchk", i), mchk, VEC[i][0]);
      @(negedge clk);
      chk($sformatf("R10 vec %0d tea single cycle", i), tea, 0);
      chk($sformatf("R10 vec %0d mchk single cycle", i), mchk, 0);
    end
    tea_en = 1; mchk_en = 1;

    // R4: stray time-out and stray end with nothing open
    @(negedge clk); tmo = 1;
    @(negedge clk); idle();
    chk("R4 stray timeout", tea, 0);
    @(negedge clk); en = 1;
    @(negedge clk); idle();
    chk("R4 stray end", tea, 0);

    // R4: time-out closes an open local single access
    @(negedge clk); st = 1; rgn = 2'b10;
    @(negedge clk); idle();
    @(negedge clk); tmo = 1;
    @(negedge clk); idle();
    chk("R4 timeout tea", tea, 1);
    @(negedge clk); en = 1;
    @(negedge clk); idle();
    chk("R4 access closed by timeout", tea, 0);

    // R5: time-out with tea disabled
    tea_en = 0;
    @(negedge clk); st = 1;
    @(negedge clk); idle(); tmo = 1;
    @(negedge clk); idle();
    chk("R5 timeout tea disabled", tea, 0);
    tea_en = 1;

    // R10: many conditions across one multi-beat access
    nt = 0; nm = 0; both = 0;
    @(negedge clk); st = 1; rgn = 2'b01; bu = 1;
    @(negedge clk); idle(); par = 1;
    @(negedge clk); idle(); dbl = 1; tmo = 1; en = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle();
      nt += tea; nm += mchk; both += (tea & mchk);
    end
    chk("R10 tea cycles", nt, 1);
    chk("R10 mchk cycles", nm, 1);
    chk("R10 same cycle", both, 1);

    // R7/R8 single-bit counting, limit 3
    @(negedge clk); st = 1; sgl = 1;
    @(negedge clk); idle(); sgl = 1; en = 1;
    @(negedge clk); idle();
    chk("R7 one step per access", cnt, 1);
    chk("R8 below limit", mchk, 0);
    acc1(2'b00, 0, 0, 0, 0, 1, 0);
    chk("R7 count 2", cnt, 2);
    chk("R8 below limit 2", mchk, 0);
    acc1(2'b00, 0, 0, 0, 0, 1, 0);
    chk("R7 count 3", cnt, 3);
    chk("R8 limit reached", mchk, 1);
    acc1(2'b00, 0, 0, 0, 0, 1, 0);
    chk("R7 saturate", cnt, 3);
    chk("R8 at limit again", mchk, 1);
    acc1(2'b00, 0, 0, 0, 0, 0, 0);
    chk("R7 no sgl no step", cnt, 3);

    // R11: mchk disabled, count still counts
    @(negedge clk); clr = 1;
    @(negedge clk); idle();
    chk("R9 clear", cnt, 0);
    mchk_en = 0; smax = 8'd1;
    acc1(2'b00, 0, 0, 0, 0, 1, 0);
    chk("R11 mchk suppressed", mchk, 0);
    chk("R11 count advances", cnt, 1);
    mchk_en = 1; smax = 8'd3;

    // R9: clear wins over step
    acc1(2'b00, 0, 0, 0, 0, 1, 1);
    chk("R9 clear beats step", cnt, 0);

    // R8: limit zero
    smax = 8'd0;
    acc1(2'b00, 0, 0, 0, 0, 1, 0);
    chk("R8 limit zero mchk", mchk, 1);
    chk("R8 limit zero count", cnt, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule